// File: doc/BRIEF.md
# Repeated String Move Engine

This block is a hardware copy loop. Given a source address, a destination address and an element count, it repeatedly reads one element from the source address and writes it to the destination address. After each element it advances both addresses by the element size and decrements the count. It stops when the count has reached zero. Elements are either single bytes or 32-bit words, chosen when the move is started.

The engine drives a single synchronous memory port. A read cycle presents the source address with the read strobe, and the memory returns the word on the following cycle. A write cycle then presents the destination address with the write strobe, the data and per-byte write enables.

The current pointer and count values are visible on output ports at all times, so their final values can be read after the move. A start request that arrives while a move is running is dropped. A start with a zero count performs no memory access and completes at once.

Top module: `strmove_engine`

## Requirements
- R1: While reset is asserted and after it is released, busy_o, done_o, mem_re_o and mem_we_o are 0, and src_o, dst_o and cnt_o are 0.
- R2: A start with cnt_i equal to 0, accepted while idle, makes no memory access. done_o is 1 in the cycle after the start edge, and busy_o stays 0.
- R3: Each element takes exactly two cycles. First comes a read cycle (mem_re_o=1, mem_addr_o equal to the current source pointer). Then comes a write cycle (mem_we_o=1, mem_addr_o equal to the current destination pointer). The element's bytes then appear at the destination in memory.
- R4: With byte_mode_i=0 (32-bit elements), every write cycle has mem_be_o=4'b1111 and carries the whole word read. After it, both pointers have advanced by 4. The memory word index is address bits [ADDR_W-1:2].
- R5: With byte_mode_i=1, every write cycle has mem_be_o with only bit dst[1:0] set. The byte taken from lane src[1:0] of the read word is placed in lane dst[1:0]. After the write, both pointers have advanced by 1.
- R6: cnt_o decrements by exactly one at the end of each write cycle. After a move of N elements, src_o and dst_o equal their start values plus N times the element size, and cnt_o is 0.
- R7: A start request while busy_o=1 is ignored: pointers, count and element size continue the running move unchanged.
- R8: done_o is a single-cycle pulse. It is high in the cycle after the last write, and busy_o is 0 in that same cycle. A start may be accepted in the done cycle.
- R9: mem_re_o and mem_we_o are never both 1, and neither is 1 while busy_o=0.
- R10: Elements are moved strictly in ascending order, one at a time. An overlapping byte move with dst = src+1 therefore replicates the first source byte across the destination.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start request, sampled on the clock edge |
| src_i | input | ADDR_W | Initial source byte address |
| dst_i | input | ADDR_W | Initial destination byte address |
| cnt_i | input | CNT_W | Number of elements to move |
| byte_mode_i | input | 1 | 1: byte elements, 0: 32-bit elements |
| mem_addr_o | output | ADDR_W | Memory byte address |
| mem_re_o | output | 1 | Memory read strobe; data returns next cycle |
| mem_we_o | output | 1 | Memory write strobe |
| mem_be_o | output | DATA_W/8 | Per-byte write enables |
| mem_wdata_o | output | DATA_W | Write data |
| mem_rdata_i | input | DATA_W | Read data, valid the cycle after mem_re_o |
| busy_o | output | 1 | A move is in progress |
| done_o | output | 1 | One-cycle pulse when a move ends |
| src_o | output | ADDR_W | Current source pointer |
| dst_o | output | ADDR_W | Current destination pointer |
| cnt_o | output | CNT_W | Remaining element count |

## Verification
A start sampled at edge T with a count of N puts the first read in the cycle after T. The write of element k (k counting from 0) follows in the cycle after edge T+2k+1. The pointer and count updates become visible, and done_o rises, in the cycle after edge T+2N; for N=0 that is the cycle right after T. The bench's reference model advances on the same edges as the design, and every output is compared at the falling edge, so each result is checked in exactly the cycle it is due. After all moves, the memory image is compared byte by byte with an independently maintained shadow copy.

// File: rtl/strmove_pkg.sv
package strmove_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RD   = 2'd1,
    ST_WR   = 2'd2
  } strm_state_e;
endpackage

// File: rtl/strmove_ctrl.sv
module strmove_ctrl
  import strmove_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        start_i,
  input  logic        start_zero_i,
  input  logic        last_i,
  output strm_state_e state_o,
  output logic        load_o,
  output logic        step_o,
  output logic        done_o
);
  strm_state_e state_q, state_d;
  logic        done_q, done_d;
  logic        idle;

  assign idle   = (state_q == ST_IDLE);
  assign load_o = idle && start_i && !start_zero_i;
  assign step_o = (state_q == ST_WR);

  always_comb begin
    state_d = state_q;
    done_d  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          if (start_zero_i) done_d = 1'b1;
          else state_d = ST_RD;
        end
      end
      ST_RD: state_d = ST_WR;
      ST_WR: begin
        if (last_i) begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
        end else begin
          state_d = ST_RD;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
    end
  end

  assign state_o = state_q;
  assign done_o  = done_q;
endmodule

// File: rtl/strmove_regs.sv
module strmove_regs #(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16,
  parameter int BYTES  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              step_i,
  input  logic [ADDR_W-1:0] src_i,
  input  logic [ADDR_W-1:0] dst_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              byte_i,
  output logic [ADDR_W-1:0] src_o,
  output logic [ADDR_W-1:0] dst_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              byte_o,
  output logic              last_o
);
  localparam logic [ADDR_W-1:0] WORD_STEP = ADDR_W'(BYTES);
  localparam logic [CNT_W-1:0]  CNT_ONE   = CNT_W'(1);

  logic [ADDR_W-1:0] src_q, dst_q, step_amt;
  logic [CNT_W-1:0]  cnt_q;
  logic              byte_q;

  assign step_amt = byte_q ? ADDR_W'(1) : WORD_STEP;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_q  <= '0;
      dst_q  <= '0;
      cnt_q  <= '0;
      byte_q <= 1'b0;
    end else if (load_i) begin
      src_q  <= src_i;
      dst_q  <= dst_i;
      cnt_q  <= cnt_i;
      byte_q <= byte_i;
    end else if (step_i) begin
      src_q <= src_q + step_amt;
      dst_q <= dst_q + step_amt;
      cnt_q <= cnt_q - CNT_ONE;
    end
  end

  assign src_o  = src_q;
  assign dst_o  = dst_q;
  assign cnt_o  = cnt_q;
  assign byte_o = byte_q;
  assign last_o = (cnt_q == CNT_ONE);
endmodule

// File: rtl/strmove_lane.sv
module strmove_lane #(
  parameter int DATA_W = 32,
  localparam int BYTES = DATA_W / 8,
  localparam int OFS_W = (BYTES > 1) ? $clog2(BYTES) : 1
) (
  input  logic [DATA_W-1:0] rdata_i,
  input  logic [OFS_W-1:0]  rd_ofs_i,
  input  logic [OFS_W-1:0]  wr_ofs_i,
  input  logic              byte_i,
  output logic [DATA_W-1:0] wdata_o,
  output logic [BYTES-1:0]  be_o
);
  logic [7:0] sel_byte;

  // byte picked from the source lane of the read word
  assign sel_byte = rdata_i[8*rd_ofs_i +: 8];

  for (genvar i = 0; i < BYTES; i++) begin : g_lane
    assign be_o[i]          = byte_i ? (wr_ofs_i == OFS_W'(i)) : 1'b1;
    assign wdata_o[8*i +: 8] = byte_i ? sel_byte : rdata_i[8*i +: 8];
  end
endmodule

// File: rtl/strmove_engine.sv
module strmove_engine
  import strmove_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16,
  parameter int DATA_W = 32,
  localparam int BYTES = DATA_W / 8,
  localparam int OFS_W = (BYTES > 1) ? $clog2(BYTES) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] src_i,
  input  logic [ADDR_W-1:0] dst_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              byte_mode_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_re_o,
  output logic              mem_we_o,
  output logic [BYTES-1:0]  mem_be_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [ADDR_W-1:0] src_o,
  output logic [ADDR_W-1:0] dst_o,
  output logic [CNT_W-1:0]  cnt_o
);
  strm_state_e state;
  logic        load, step, last, byte_q, start_zero;

  assign start_zero = (cnt_i == '0);

  strmove_ctrl i_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .start_zero_i(start_zero),
    .last_i      (last),
    .state_o     (state),
    .load_o      (load),
    .step_o      (step),
    .done_o      (done_o)
  );

  strmove_regs #(
    .ADDR_W(ADDR_W),
    .CNT_W (CNT_W),
    .BYTES (BYTES)
  ) i_regs (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(load),
    .step_i(step),
    .src_i (src_i),
    .dst_i (dst_i),
    .cnt_i (cnt_i),
    .byte_i(byte_mode_i),
    .src_o (src_o),
    .dst_o (dst_o),
    .cnt_o (cnt_o),
    .byte_o(byte_q),
    .last_o(last)
  );

  strmove_lane #(
    .DATA_W(DATA_W)
  ) i_lane (
    .rdata_i (mem_rdata_i),
    .rd_ofs_i(src_o[OFS_W-1:0]),
    .wr_ofs_i(dst_o[OFS_W-1:0]),
    .byte_i  (byte_q),
    .wdata_o (mem_wdata_o),
    .be_o    (mem_be_o)
  );

  assign mem_re_o   = (state == ST_RD);
  assign mem_we_o   = (state == ST_WR);
  assign mem_addr_o = mem_re_o ? src_o : dst_o;
  assign busy_o     = (state != ST_IDLE);
endmodule

// File: rtl/strmove_chk.sv
module strmove_chk #(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16,
  parameter int BYTES  = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic [CNT_W-1:0]  cnt_i,
  input logic              busy_o,
  input logic              done_o,
  input logic              mem_re_o,
  input logic              mem_we_o,
  input logic [BYTES-1:0]  mem_be_o,
  input logic [ADDR_W-1:0] src_o,
  input logic [ADDR_W-1:0] dst_o,
  input logic [CNT_W-1:0]  cnt_o
);
  a_r9_strobe_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_re_o && mem_we_o));

  a_r9_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!mem_re_o && !mem_we_o));

  a_r3_read_then_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_re_o |=> mem_we_o);

  a_r3_write_after_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> $past(mem_re_o));

  a_r6_cnt_dec: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |=> (cnt_o == $past(cnt_o) - CNT_W'(1)));

  a_r4_word_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_o && (mem_be_o == '1)) |=>
      (src_o == $past(src_o) + ADDR_W'(BYTES)) && (dst_o == $past(dst_o) + ADDR_W'(BYTES)));

  a_r5_byte_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_o && (mem_be_o != '1)) |=>
      (src_o == $past(src_o) + ADDR_W'(1)) && (dst_o == $past(dst_o) + ADDR_W'(1)));

  a_r5_be_shape: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> ((mem_be_o == '1) || ($countones(mem_be_o) == 1)));

  a_r7_hold_between: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !mem_we_o) |=> ($stable(src_o) && $stable(dst_o) && $stable(cnt_o)));

  a_r8_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r8_done_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  a_r2_zero_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o && (cnt_i == '0)) |=> (done_o && !busy_o && !mem_re_o));
endmodule

bind strmove_engine strmove_chk #(
  .ADDR_W(ADDR_W),
  .CNT_W (CNT_W),
  .BYTES (BYTES)
) i_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .start_i (start_i),
  .cnt_i   (cnt_i),
  .busy_o  (busy_o),
  .done_o  (done_o),
  .mem_re_o(mem_re_o),
  .mem_we_o(mem_we_o),
  .mem_be_o(mem_be_o),
  .src_o   (src_o),
  .dst_o   (dst_o),
  .cnt_o   (cnt_o)
);

// File: tb/test_strmove_engine.sv
`timescale 1ns/1ps
module test_strmove_engine;
  localparam int AW = 16;
  localparam int CW = 16;
  localparam int DW = 32;
  localparam int MB = 1024;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          start_i = 1'b0;
  logic [AW-1:0] src_i = '0, dst_i = '0;
  logic [CW-1:0] cnt_i = '0;
  logic          byte_mode_i = 1'b0;
  logic [AW-1:0] mem_addr_o;
  logic          mem_re_o, mem_we_o;
  logic [3:0]    mem_be_o;
  logic [DW-1:0] mem_wdata_o;
  logic [DW-1:0] mem_rdata_i = '0;
  logic          busy_o, done_o;
  logic [AW-1:0] src_o, dst_o;
  logic [CW-1:0] cnt_o;

  int tests = 0, fails = 0;
  bit fin = 0;

  always #2.5 clk_i = ~clk_i;

  strmove_engine i_strmove_engine (.*);

  // memory behind the port: synchronous read, byte-enabled write
  logic [7:0] mem [MB];
  always @(posedge clk_i) begin
    if (mem_re_o) begin
      for (int k = 0; k < 4; k++)
        mem_rdata_i[8*k +: 8] <= mem[{mem_addr_o[9:2], 2'(k)}];
    end
    if (mem_we_o) begin
      for (int k = 0; k < 4; k++)
        if (mem_be_o[k]) mem[{mem_addr_o[9:2], 2'(k)}] <= mem_wdata_o[8*k +: 8];
    end
  end

  // behavioural reference model
  logic [7:0] sh [MB];
  int m_st, m_src, m_dst, m_cnt;
  bit m_byte, m_done;

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_st = 0; m_src = 0; m_dst = 0; m_cnt = 0; m_byte = 0; m_done = 0;
    end else begin
      m_done = 0;
      if (m_st == 0) begin
        if (start_i) begin
          if (cnt_i == 0) m_done = 1;
          else begin
            m_st = 1; m_src = src_i; m_dst = dst_i; m_cnt = cnt_i; m_byte = byte_mode_i;
          end
        end
      end else if (m_st == 1) begin
        m_st = 2;
      end else begin
        if (m_byte) sh[m_dst % MB] = sh[m_src % MB];
        else for (int k = 0; k < 4; k++)
          sh[((m_dst & ~3) + k) % MB] = sh[((m_src & ~3) + k) % MB];
        m_src = (m_src + (m_byte ? 1 : 4)) & 16'hFFFF;
        m_dst = (m_dst + (m_byte ? 1 : 4)) & 16'hFFFF;
        m_cnt = m_cnt - 1;
        if (m_cnt == 0) begin m_st = 0; m_done = 1; end
        else m_st = 1;
      end
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s at %0t: actual=%0h expected=%0h", req, what, $time, act, exp);
    end
  endtask

  always @(negedge clk_i) begin
    if (rst_ni && !fin) begin
      check(busy_o == (m_st != 0), "R8", "busy_o", busy_o, m_st != 0);
      check(done_o == m_done, "R8", "done_o", done_o, m_done);
      check(mem_re_o == (m_st == 1), "R3", "mem_re_o", mem_re_o, m_st == 1);
      check(mem_we_o == (m_st == 2), "R9", "mem_we_o", mem_we_o, m_st == 2);
      if (m_st == 1) check(mem_addr_o == m_src, "R3", "read addr", mem_addr_o, m_src);
      if (m_st == 2) begin
        check(mem_addr_o == m_dst, "R3", "write addr", mem_addr_o, m_dst);
        if (m_byte) check(mem_be_o == (4'b1 << m_dst[1:0]), "R5", "byte be", mem_be_o, 4'b1 << m_dst[1:0]);
        else        check(mem_be_o == 4'hF, "R4", "word be", mem_be_o, 4'hF);
      end
      check(src_o == m_src && dst_o == m_dst, "R4 R5", "pointers",
            {src_o, dst_o}, {m_src[15:0], m_dst[15:0]});
      check(cnt_o == m_cnt, "R6", "cnt_o", cnt_o, m_cnt);
    end
  end

  task automatic kick(input int s, input int d, input int n, input bit b);
    @(negedge clk_i);
    start_i = 1; src_i = AW'(s); dst_i = AW'(d); cnt_i = CW'(n); byte_mode_i = b;
    @(negedge clk_i);
    start_i = 0;
  endtask

  task automatic wait_done();
    int guard = 0;
    while (!done_o && guard < 5000) begin @(negedge clk_i); guard++; end
  endtask

  task automatic move(input int s, input int d, input int n, input bit b, input string req);
    int st;
    st = b ? 1 : 4;
    kick(s, d, n, b);
    wait_done();
    // R6 final values from the requirement formula
    check(src_o == AW'(s + n*st), req, "final src", src_o, AW'(s + n*st));
    check(dst_o == AW'(d + n*st), req, "final dst", dst_o, AW'(d + n*st));
    check(cnt_o == 0, req, "final cnt", cnt_o, 0);
    @(negedge clk_i);
  endtask

  initial begin
    for (int b = 0; b < MB; b++) begin
      mem[b] = 8'((b * 13 + 7) & 255);
      sh[b]  = 8'((b * 13 + 7) & 255);
    end
    repeat (3) @(negedge clk_i);
    // R1 during reset
    check(!busy_o && !done_o && !mem_re_o && !mem_we_o, "R1", "idle in reset",
          {busy_o, done_o, mem_re_o, mem_we_o}, 0);
    check(src_o == 0 && dst_o == 0 && cnt_o == 0, "R1", "regs in reset", {src_o, dst_o, cnt_o}, 0);
    rst_ni = 1;
    @(negedge clk_i);
    check(!busy_o && !done_o, "R1", "idle after reset", {busy_o, done_o}, 0);

    move(16'h040, 16'h100, 5, 0, "R4 R6");
    move(16'h081, 16'h203, 7, 1, "R5 R6");

    // R2: zero count
    kick(16'h050, 16'h150, 0, 0);
    check(done_o && !busy_o && !mem_re_o, "R2", "zero count done", {done_o, busy_o, mem_re_o}, 3'b100);
    check(src_o == 16'h081 + 7 && cnt_o == 0, "R2", "regs untouched", src_o, 16'h081 + 7);
    @(negedge clk_i);

    // R7: start while busy
    kick(16'h2A0, 16'h2C0, 4, 1);
    repeat (2) @(negedge clk_i);
    kick(16'h010, 16'h020, 9, 0);
    wait_done();
    check(src_o == 16'h2A4 && dst_o == 16'h2C4, "R7", "ignored start", {src_o, dst_o}, {16'h2A4, 16'h2C4});
    @(negedge clk_i);

    // R10: overlapping forward move
    move(16'h300, 16'h301, 6, 1, "R10");
    for (int k = 1; k <= 6; k++)
      check(mem[16'h300 + k] == mem[16'h300], "R10", "replicated byte", mem[16'h300 + k], mem[16'h300]);

    // R8: back-to-back, start in the done cycle
    kick(16'h380, 16'h3C0, 2, 0);
    wait_done();
    start_i = 1; src_i = 16'h3C0; dst_i = 16'h390; cnt_i = 3; byte_mode_i = 1;
    @(negedge clk_i);
    start_i = 0;
    check(busy_o, "R8", "start in done cycle", busy_o, 1);
    wait_done();
    repeat (2) @(negedge clk_i);

    // R3: final memory image
    begin
      int bad = 0;
      for (int b = 0; b < MB; b++) if (mem[b] !== sh[b]) bad++;
      check(bad == 0, "R3", "memory image mismatches", bad, 0);
    end
    fin = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk_i);
    if (!fin) begin
      fin = 1;
      tests++; fails++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule